// File: doc/BRIEF.md
# Register File with Optional Write Forwarding

This block is a small general-purpose register array: eight words with one write port and two independent read ports. It has no handshake. Every read port shows the word its select input points at, through combinational logic only. A write lands on the rising clock edge when the write enable is high. A synchronous, active-high reset clears every word to zero.

A build-time parameter picks one of two read behaviours. In plain mode, a word being written is still read at its old value during the write cycle. In forwarding mode, a read port whose select equals the select of an active write returns the incoming write data in that same cycle. The ports are the same in both modes, and each read port decides on forwarding by itself.

An error flag is raised when the write enable or any select carries an unknown value in simulation. The word width and the word count are parameters, so 32-bit or 64-bit variants need only a parameter change.

Top module: `bypass_regfile`

## Requirements
- R1: The array holds 8 words of DATA_W bits (16 by default). When no write is active, each read port shows the word addressed by its 3-bit select during the same cycle.
- R2: When wr_en is high and rst is low, the word addressed by wr_sel holds wr_data after the next rising clock edge.
- R3: When wr_en is low and rst is low, a rising edge changes no word, whatever wr_sel and wr_data carry.
- R4: When rst is high at a rising edge, every word becomes zero. The zero is visible on the read ports from the following cycle.
- R5: Reset wins over a write on the same edge. A word written while rst is high reads zero afterwards.
- R6: In plain mode (BYPASS=0), a read port addressing the word being written shows the stored (old) value during the write cycle.
- R7: In forwarding mode (BYPASS=1), a read port whose select equals wr_sel while wr_en is high shows wr_data in that cycle. A port that does not match shows the stored value.
- R8: Both read ports may address the same word, or the word being written, at once. Each port resolves forwarding on its own select.
- R9: err is low whenever wr_en and all three selects carry known values. It goes high if any of them is X or Z.
- R10: In forwarding mode, a matching read during a reset cycle still returns wr_data. A read that does not match returns the word as it was before the reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear of all words |
| wr_en | input | 1 | Write enable |
| wr_sel | input | 3 | Word to be written |
| wr_data | input | DATA_W | Data to be written |
| rd0_sel | input | 3 | Word selected for read port 0 |
| rd0_data | output | DATA_W | Read port 0 data |
| rd1_sel | input | 3 | Word selected for read port 1 |
| rd1_data | output | DATA_W | Read port 1 data |
| err | output | 1 | Unknown value on a control input |

## Verification
A word that was corrupted, missed a write, or took a stray write becomes visible as soon as either read port selects it. Because reads are combinational, the fault shows in the very first cycle after the bad edge, so the bench reads back every word after each kind of update. A fault in the forwarding path shows only in cycles where a write and a read address match. The same cycle tells the two modes apart: plain mode must show the old value and forwarding mode the new one. Both modes therefore run side by side on the same stimulus.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int unsigned RF_WIDTH_DEFAULT = 16;
  localparam int unsigned RF_WORDS_DEFAULT = 8;

  typedef enum logic {
    RD_PLAIN   = 1'b0,
    RD_FORWARD = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/rf_word.sv
module rf_word #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end

  logic started;
  always_ff @(posedge clk) started <= 1'b1;

  assert_cleared_R4: assert property (@(posedge clk) disable iff (rst)
    (started && $past(rst)) |-> (q == '0));
  assert_loaded_R2: assert property (@(posedge clk) disable iff (rst)
    (started && $past(load && !rst)) |-> (q == $past(d)));
  assert_held_R3: assert property (@(posedge clk) disable iff (rst)
    (started && $past(!load && !rst)) |-> $stable(q));
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned WORDS  = 8,
  parameter int unsigned SEL_W  = 3,
  parameter rf_pkg::rd_mode_e MODE = rf_pkg::RD_FORWARD
) (
  input  logic [WORDS-1:0][DATA_W-1:0] words,
  input  logic [SEL_W-1:0]             sel,
  input  logic                         wr_en,
  input  logic [SEL_W-1:0]             wr_sel,
  input  logic [DATA_W-1:0]            wr_data,
  output logic [DATA_W-1:0]            data
);
  logic [DATA_W-1:0] stored;

  always_comb begin
    stored = '0;
    for (int i = 0; i < WORDS; i++) begin
      if (sel == SEL_W'(i)) stored = words[i];
    end
  end

  generate
    if (MODE == rf_pkg::RD_FORWARD) begin : g_fwd
      logic hit;
      assign hit  = wr_en && (wr_sel == sel);
      assign data = hit ? wr_data : stored;
    end else begin : g_plain
      assign data = stored;
    end
  endgenerate
endmodule

// File: rtl/rf_ctrl_check.sv
module rf_ctrl_check #(
  parameter int unsigned SEL_W = 3
) (
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [SEL_W-1:0] rd0_sel,
  input  logic [SEL_W-1:0] rd1_sel,
  output logic             err
);
  always_comb begin
    err = $isunknown({wr_en, wr_sel, rd0_sel, rd1_sel});
  end
endmodule

// File: rtl/bypass_regfile.sv
module bypass_regfile #(
  parameter int unsigned DATA_W = rf_pkg::RF_WIDTH_DEFAULT,
  parameter int unsigned WORDS  = rf_pkg::RF_WORDS_DEFAULT,
  parameter bit          BYPASS = 1'b1,
  localparam int unsigned SEL_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  rd0_sel,
  output logic [DATA_W-1:0] rd0_data,
  input  logic [SEL_W-1:0]  rd1_sel,
  output logic [DATA_W-1:0] rd1_data,
  output logic              err
);
  localparam rf_pkg::rd_mode_e MODE = BYPASS ? rf_pkg::RD_FORWARD : rf_pkg::RD_PLAIN;

  logic [WORDS-1:0][DATA_W-1:0] words;
  logic [WORDS-1:0]             load;

  generate
    for (genvar i = 0; i < WORDS; i++) begin : g_word
      assign load[i] = wr_en && (wr_sel == SEL_W'(i));
      rf_word #(.DATA_W(DATA_W)) u_word (
        .clk (clk),
        .rst (rst),
        .load(load[i]),
        .d   (wr_data),
        .q   (words[i])
      );
    end
  endgenerate

  rf_read_port #(.DATA_W(DATA_W), .WORDS(WORDS), .SEL_W(SEL_W), .MODE(MODE)) u_rd0 (
    .words(words), .sel(rd0_sel), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .data(rd0_data)
  );

  rf_read_port #(.DATA_W(DATA_W), .WORDS(WORDS), .SEL_W(SEL_W), .MODE(MODE)) u_rd1 (
    .words(words), .sel(rd1_sel), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .data(rd1_data)
  );

  rf_ctrl_check #(.SEL_W(SEL_W)) u_chk (
    .wr_en(wr_en), .wr_sel(wr_sel), .rd0_sel(rd0_sel), .rd1_sel(rd1_sel), .err(err)
  );

  logic started;
  always_ff @(posedge clk) started <= 1'b1;

  logic hit0, hit1;
  assign hit0 = wr_en && (wr_sel == rd0_sel);
  assign hit1 = wr_en && (wr_sel == rd1_sel);

  assert_fwd_port0_R7: assert property (@(posedge clk) disable iff (rst)
    (BYPASS && hit0) |-> (rd0_data == wr_data));
  assert_fwd_port1_R8: assert property (@(posedge clk) disable iff (rst)
    (BYPASS && hit1) |-> (rd1_data == wr_data));
  assert_readback_R2: assert property (@(posedge clk) disable iff (rst)
    (started && $past(wr_en && !rst) && (rd0_sel == $past(wr_sel)) && !(BYPASS && hit0))
      |-> (rd0_data == $past(wr_data)));
  assert_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (started && $past(!wr_en && !rst) && $stable(rd1_sel) && !(BYPASS && hit1))
      |-> $stable(rd1_data));
  assert_zero_after_rst_R4: assert property (@(posedge clk) disable iff (rst)
    (started && $past(rst) && !(BYPASS && hit0)) |-> (rd0_data == '0));
  assert_no_err_R9: assert property (@(posedge clk) disable iff (rst)
    !$isunknown({wr_en, wr_sel, rd0_sel, rd1_sel}) |-> !err);
endmodule

// File: tb/sim_bypass_regfile.sv
`timescale 1ns/1ps
module sim_bypass_regfile;
  logic        clk = 1'b0;
  logic        rst, wr_en;
  logic [2:0]  wr_sel, rd0_sel, rd1_sel;
  logic [15:0] wr_data;
  logic [15:0] f0, f1, p0, p1;
  logic        ferr, perr;
  logic [15:0] mdl [8];
  int compared = 0, mismatched = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bypass_regfile #(.DATA_W(16), .WORDS(8), .BYPASS(1'b1)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd0_sel(rd0_sel), .rd0_data(f0), .rd1_sel(rd1_sel), .rd1_data(f1), .err(ferr));

  bypass_regfile #(.DATA_W(16), .WORDS(8), .BYPASS(1'b0)) u1 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd0_sel(rd0_sel), .rd0_data(p0), .rd1_sel(rd1_sel), .rd1_data(p1), .err(perr));

  task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // One cycle: drive at the falling edge, compare 1 ns later, update the model at the rising edge.
  task automatic cyc(string tag, logic r, logic we, logic [2:0] ws, logic [15:0] wd,
                     logic [2:0] s0, logic [2:0] s1);
    @(negedge clk);
    rst = r; wr_en = we; wr_sel = ws; wr_data = wd; rd0_sel = s0; rd1_sel = s1;
    #1;
    check(tag, "fwd port0", f0, (we && ws == s0) ? wd : mdl[s0]);
    check(tag, "fwd port1", f1, (we && ws == s1) ? wd : mdl[s1]);
    check(tag, "plain port0", p0, mdl[s0]);
    check(tag, "plain port1", p1, mdl[s1]);
    check("R9", "err fwd", {15'd0, ferr}, 16'd0);
    check("R9", "err plain", {15'd0, perr}, 16'd0);
    @(posedge clk);
    if (r) for (int i = 0; i < 8; i++) mdl[i] = '0;
    else if (we) mdl[ws] = wd;
  endtask

  task automatic sweep(string tag);
    for (int i = 0; i < 8; i++) cyc(tag, 0, 0, 3'(i), 16'hDEAD, 3'(i), 3'(7 - i));
  endtask

  task automatic sc_reset_state();
    for (int i = 0; i < 8; i++) mdl[i] = '0;
    sweep("R4");
  endtask

  task automatic sc_fill();
    for (int i = 0; i < 8; i++) cyc("R2", 0, 1, 3'(i), 16'h1357 ^ (16'(i) * 16'h1111), 3'(i), 3'(i + 1));
    sweep("R1");
  endtask

  task automatic sc_hold();
    for (int i = 0; i < 8; i++) cyc("R3", 0, 0, 3'(i), 16'hFFFF, 3'(7 - i), 3'(i));
    sweep("R3");
  endtask

  task automatic sc_same_cycle();
    cyc("R6", 0, 1, 3'd3, 16'hBEEF, 3'd3, 3'd2);
    cyc("R7", 0, 1, 3'd5, 16'h0F0F, 3'd4, 3'd5);
    cyc("R7", 0, 0, 3'd5, 16'h1234, 3'd5, 3'd3);
  endtask

  task automatic sc_dual();
    cyc("R8", 0, 1, 3'd6, 16'hA0A0, 3'd6, 3'd6);
    cyc("R8", 0, 1, 3'd0, 16'h5555, 3'd6, 3'd6);
    cyc("R8", 0, 1, 3'd1, 16'h7777, 3'd0, 3'd1);
    sweep("R8");
  endtask

  task automatic sc_reset_bypass();
    cyc("R10", 1, 1, 3'd2, 16'hCAFE, 3'd2, 3'd4);
    cyc("R5", 0, 0, 3'd2, 16'h0000, 3'd2, 3'd4);
    sweep("R4");
  endtask

  initial begin
    rst = 1; wr_en = 0; wr_sel = 0; wr_data = 0; rd0_sel = 0; rd1_sel = 0;
    repeat (3) @(posedge clk);
    sc_reset_state();
    sc_fill();
    sc_hold();
    sc_same_cycle();
    sc_dual();
    sc_reset_bypass();
    sc_fill();
    sc_reset_bypass();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule